// File: doc/BRIEF.md
# Masked GPIO Bank with Edge and Level Interrupts

This block is a bank of general-purpose pins behind a simple APB-style register bus. Each pin has an output latch, a direction bit that enables its driver, and a per-pin access mask that decides whether software may see or change that pin's data bit. Pin inputs are brought into the clock domain through a synchroniser chain. Only the last stage of that chain feeds data reads and interrupt detection.

Every pin can raise an interrupt. A per-pin sense bit picks level or edge detection. A both-edges bit and a polarity bit then decide which edge or level counts. Edge events are latched until software clears them by writing ones. Level conditions track the pin directly. Software reads the raw condition and the enabled (masked) condition at separate offsets. A single registered interrupt line reports whether any enabled condition is present.

The bus has no wait states. A read is captured during the setup phase, so the read data is valid throughout the access phase. A write takes effect at the clock edge that ends the access phase.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset every register reads 0, `pin_oe`, `pin_out` and `irq` are 0, and `prdata` is 0.
- R2: A write to the data register (offset 0x00) changes only those output-latch bits whose access-mask bit (offset 0x04) is 1. The other latch bits keep their value, and `pin_out` shows the latch.
- R3: A read of the data register returns 0 for every bit whose access-mask bit is 0. An unmasked bit returns the output latch when the pin is an output, and the synchronised pin value when it is an input.
- R4: The direction register (offset 0x08) drives `pin_oe` directly: 1 makes the pin an output and 0 makes it an input.
- R5: A change on `pin_in` passes through a two-flop synchroniser. A read whose setup phase is at the second clock edge after the change still returns the old value. A read whose setup phase is at a later edge returns the new value.
- R6: With sense bit 0 (offset 0x0C) and both-edges bit 0 (offset 0x10), a polarity bit of 1 (offset 0x14) latches rising edges only, and a polarity bit of 0 latches falling edges only.
- R7: With sense bit 0 and both-edges bit 1, rising and falling edges are both latched.
- R8: With sense bit 1, the raw status bit equals the synchronised pin when the polarity bit is 1, and its inverse when the polarity bit is 0. Clear writes do not affect it.
- R9: The raw status register (offset 0x1C) shows conditions regardless of enables. The masked status register (offset 0x20) equals the raw status ANDed with the enable register (offset 0x18).
- R10: Writing the clear register (offset 0x24) clears each latched edge bit written as 1 and leaves bits written as 0 unchanged. A latched edge remains set after the pin returns to its former level. The clear register reads as 0.
- R11: `irq` is the OR of all masked status bits, registered, one clock after the status it reflects.
- R12: Read data is captured at the setup-phase edge, so it is valid during the access phase. An access with a nonzero `paddr[1:0]`, or to an unmapped offset (0x28 and above), reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | W | Write data |
| prdata | output | W | Registered read data |
| pin_in | input | W | Asynchronous pin inputs |
| pin_out | output | W | Output latch value to the pad drivers |
| pin_oe | output | W | Per-pin output enable |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the block with its defaults: 16 pins, a 6-bit address and a two-stage synchroniser. With these values the whole offset space, including the unmapped slots from 0x28 to 0x3C and misaligned addresses, can be reached from the bus, and every pin can be given its own mix of sense, edge and polarity settings. A behavioural model that runs cycle by cycle follows the synchroniser latency, the edge latching, clear priority and the one-cycle interrupt delay. Its values are compared with the outputs on every clock, through directed sequences and a long run of random pin toggles and register accesses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Register index = paddr[5:2]; widths of the decode field
  localparam int unsigned REG_IDX_W = 4;
  localparam int unsigned REG_IDX_LSB = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_DATA  = 4'd0,
    RG_MASK  = 4'd1,
    RG_DIR   = 4'd2,
    RG_SENSE = 4'd3,
    RG_BOTH  = 4'd4,
    RG_POL   = 4'd5,
    RG_IEN   = 4'd6,
    RG_RAW   = 4'd7,
    RG_MSTAT = 4'd8,
    RG_CLR   = 4'd9
  } reg_sel_e;
endpackage

// File: rtl/gib_sync.sv
module gib_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev <= '0;
    end else begin
      chain[0] <= pin_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[STAGES-1];
    end
  end

  assign cur = chain[STAGES-1];
endmodule

// File: rtl/gib_detect.sv
module gib_detect #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] lat,
  output logic [W-1:0] raw
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, hit;
    assign rise = cur[i] & ~prev[i];
    assign fall = ~cur[i] & prev[i];
    assign hit  = ~sense[i] & (both[i] ? (rise | fall) : (pol[i] ? rise : fall));

    // a new edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst) lat[i] <= 1'b0;
      else     lat[i] <= (lat[i] & ~clr[i]) | hit;
    end

    assign raw[i] = sense[i] ? ~(cur[i] ^ pol[i]) : lat[i];
  end
endmodule

// File: rtl/gib_regs.sv
module gib_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [W-1:0]  pwdata,
  input  logic [W-1:0]  pin_sync,
  input  logic [W-1:0]  raw,
  output logic [W-1:0]  prdata,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  dmsk_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  sense_q,
  output logic [W-1:0]  both_q,
  output logic [W-1:0]  pol_q,
  output logic [W-1:0]  ien_q,
  output logic [W-1:0]  mis,
  output logic [W-1:0]  clr
);
  localparam int unsigned IDX_MSB = REG_IDX_LSB + REG_IDX_W - 1;

  logic [REG_IDX_W-1:0] idx;
  logic                 addr_ok, wr_en, rd_setup;
  logic [W-1:0]         data_view, rd_mux;

  assign idx      = paddr[IDX_MSB:REG_IDX_LSB];
  assign addr_ok  = (paddr[REG_IDX_LSB-1:0] == '0) && ((paddr >> (IDX_MSB + 1)) == '0);
  assign wr_en    = psel & penable & pwrite & addr_ok;
  assign rd_setup = psel & ~penable & ~pwrite;

  assign mis       = raw & ien_q;
  assign data_view = ((dir_q & out_q) | (~dir_q & pin_sync)) & dmsk_q;
  assign clr       = (wr_en && idx == RG_CLR) ? pwdata : '0;

  always_comb begin
    case (idx)
      RG_DATA:  rd_mux = data_view;
      RG_MASK:  rd_mux = dmsk_q;
      RG_DIR:   rd_mux = dir_q;
      RG_SENSE: rd_mux = sense_q;
      RG_BOTH:  rd_mux = both_q;
      RG_POL:   rd_mux = pol_q;
      RG_IEN:   rd_mux = ien_q;
      RG_RAW:   rd_mux = raw;
      RG_MSTAT: rd_mux = mis;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dmsk_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
      prdata  <= '0;
    end else begin
      if (rd_setup) prdata <= addr_ok ? rd_mux : '0;
      if (wr_en) begin
        case (idx)
          RG_DATA:  out_q   <= (out_q & ~dmsk_q) | (pwdata & dmsk_q);
          RG_MASK:  dmsk_q  <= pwdata;
          RG_DIR:   dir_q   <= pwdata;
          RG_SENSE: sense_q <= pwdata;
          RG_BOTH:  both_q  <= pwdata;
          RG_POL:   pol_q   <= pwdata;
          RG_IEN:   ien_q   <= pwdata;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [W-1:0]      pwdata,
  output logic [W-1:0]      prdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq
);
  logic [W-1:0] cur, prev, raw, lat, mis, clr;
  logic [W-1:0] out_q, dmsk_q, dir_q, sense_q, both_q, pol_q, ien_q;

  gib_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_async(pin_in), .cur(cur), .prev(prev)
  );

  gib_detect #(.W(W)) u_detect (
    .clk(clk), .rst(rst), .cur(cur), .prev(prev),
    .sense(sense_q), .both(both_q), .pol(pol_q), .clr(clr),
    .lat(lat), .raw(raw)
  );

  gib_regs #(.W(W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pin_sync(cur), .raw(raw),
    .prdata(prdata), .out_q(out_q), .dmsk_q(dmsk_q), .dir_q(dir_q),
    .sense_q(sense_q), .both_q(both_q), .pol_q(pol_q), .ien_q(ien_q),
    .mis(mis), .clr(clr)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |mis;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gib_checker.sv
module gib_checker #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [W-1:0]  pwdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic          irq,
  input logic [W-1:0]  mis,
  input logic [W-1:0]  lat,
  input logic [W-1:0]  dmsk
);
  logic wr;
  assign wr = psel & penable & pwrite;

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
    (wr && paddr == AW'(8)) |=> (pin_oe == $past(pwdata)));  // R4

  AST_MASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr && paddr == AW'(0)) |=> ((pin_out & ~$past(dmsk)) == ($past(pin_out) & ~$past(dmsk))));  // R2

  AST_UNMASKED_BITS_TAKE: assert property (@(posedge clk) disable iff (rst)
    (wr && paddr == AW'(0)) |=> ((pin_out & $past(dmsk)) == ($past(pwdata) & $past(dmsk))));  // R2

  AST_IRQ_IS_OR_OF_MIS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|mis)));  // R11

  AST_LATCH_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(wr && paddr == AW'(36)) |=> ((lat & $past(lat)) == $past(lat)));  // R10
endmodule

bind gpio_irq_bank gib_checker #(.W(W), .AW(ADDR_W)) u_check (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq(irq), .mis(mis), .lat(lat), .dmsk(dmsk_q)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int W = 16;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [W-1:0]  pwdata = '0;
  logic [W-1:0]  pin_in = 16'hA5A5;
  logic [W-1:0]  prdata, pin_out, pin_oe;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;
  bit done    = 0;

  always #10 clk = ~clk;  // 50 MHz

  gpio_irq_bank uut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [W-1:0] m_s1, m_s2, m_prev, m_lat, m_out, m_msk, m_dir, m_is, m_ibe, m_iev, m_ie, m_rd;
  logic         m_irq;

  function automatic logic [W-1:0] m_raw();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = m_is[i] ? (m_iev[i] ? m_s2[i] : !m_s2[i]) : m_lat[i];
    return r;
  endfunction

  function automatic logic [W-1:0] m_read(input logic [AW-1:0] a);
    logic [W-1:0] v;
    v = '0;
    if (a[1:0] == 2'b00) begin
      case (int'(a[5:2]))
        0: for (int i = 0; i < W; i++) v[i] = m_msk[i] && (m_dir[i] ? m_out[i] : m_s2[i]);
        1: v = m_msk;
        2: v = m_dir;
        3: v = m_is;
        4: v = m_ibe;
        5: v = m_iev;
        6: v = m_ie;
        7: v = m_raw();
        8: v = m_raw() & m_ie;
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_lat = '0; m_out = '0; m_msk = '0;
      m_dir = '0; m_is = '0; m_ibe = '0; m_iev = '0; m_ie = '0; m_rd = '0; m_irq = 0;
    end else begin
      logic [W-1:0] hit, clr;
      bit wr;
      wr = psel && penable && pwrite && (paddr[1:0] == 2'b00);
      if (psel && !penable && !pwrite) m_rd = m_read(paddr);
      m_irq = |(m_raw() & m_ie);
      for (int i = 0; i < W; i++) begin
        bit rise, fall;
        rise = m_s2[i] && !m_prev[i];
        fall = !m_s2[i] && m_prev[i];
        hit[i] = !m_is[i] && (m_ibe[i] ? (rise || fall) : (m_iev[i] ? rise : fall));
      end
      clr = (wr && paddr[5:2] == 4'd9) ? pwdata : '0;
      if (wr) begin
        case (int'(paddr[5:2]))
          0: for (int i = 0; i < W; i++) if (m_msk[i]) m_out[i] = pwdata[i];
          1: m_msk = pwdata;
          2: m_dir = pwdata;
          3: m_is  = pwdata;
          4: m_ibe = pwdata;
          5: m_iev = pwdata;
          6: m_ie  = pwdata;
          default: ;
        endcase
      end
      for (int i = 0; i < W; i++) m_lat[i] = (m_lat[i] && !clr[i]) || hit[i];
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
    started = 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check("R11 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      check("R2 pin_out vs model", {16'd0, pin_out}, {16'd0, m_out});
      check("R4 pin_oe vs model", {16'd0, pin_oe}, {16'd0, m_dir});
      check("R12 prdata vs model", {16'd0, prdata}, {16'd0, m_rd});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); d = prdata; penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic expect_read(input string tag, input logic [AW-1:0] a, input logic [W-1:0] e);
    logic [W-1:0] d;
    bus_read(a, d);
    check(tag, {16'd0, d}, {16'd0, e});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++; n_tests++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- directed and random stimulus ----------------
  initial begin
    logic [W-1:0] d;
    repeat (5) @(negedge clk);
    rst = 0;
    idle(2);
    // R1: reset state
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 pin_oe after reset", {16'd0, pin_oe}, 32'd0);
    check("R1 pin_out after reset", {16'd0, pin_out}, 32'd0);
    for (int r = 0; r < 10; r++) expect_read("R1 register reset value", AW'(r * 4), '0);

    // R2 / R4: masked writes
    bus_write(6'h04, 16'h00FF);
    bus_write(6'h08, 16'hFFFF);
    bus_write(6'h00, 16'h1234);
    check("R2 low byte written", {16'd0, pin_out}, 32'h0034);
    bus_write(6'h04, 16'hFF00);
    bus_write(6'h00, 16'hABCD);
    check("R2 only unmasked bits change", {16'd0, pin_out}, 32'hAB34);
    check("R4 direction drives pin_oe", {16'd0, pin_oe}, 32'hFFFF);

    // R3: data read per direction and mask
    bus_write(6'h04, 16'hFFFF);
    bus_write(6'h08, 16'hFF00);
    pin_in = 16'h5A5A;
    idle(4);
    expect_read("R3 mixed directions", 6'h00, 16'hAB5A);
    bus_write(6'h04, 16'h0F0F);
    expect_read("R3 masked bits read 0", 6'h00, 16'h0B0A);
    check("R4 pin_oe partial", {16'd0, pin_oe}, 32'hFF00);

    // R5: synchroniser latency
    bus_write(6'h08, 16'h0000);
    bus_write(6'h04, 16'hFFFF);
    pin_in = 16'h0000;
    idle(4);
    @(negedge clk); pin_in = 16'h0001;
    expect_read("R5 value not yet through synchroniser", 6'h00, 16'h0000);
    expect_read("R5 value through synchroniser", 6'h00, 16'h0001);

    // R6: single edges
    pin_in = 16'h0000;
    idle(4);
    bus_write(6'h24, 16'hFFFF);
    bus_write(6'h14, 16'h0001);
    bus_write(6'h18, 16'hFFFF);
    expect_read("R10 cleared latches", 6'h1C, 16'h0000);
    pin_in = 16'h0001;
    idle(6);
    expect_read("R6 rising edge latched", 6'h1C, 16'h0001);
    expect_read("R9 masked status enabled", 6'h20, 16'h0001);
    check("R11 irq asserted", {31'd0, irq}, 32'd1);
    pin_in = 16'h0000;
    idle(6);
    expect_read("R10 latch survives pin return", 6'h1C, 16'h0001);
    bus_write(6'h24, 16'h0001);
    idle(3);
    expect_read("R6 falling edge ignored when rising selected", 6'h1C, 16'h0000);
    check("R11 irq released", {31'd0, irq}, 32'd0);
    pin_in = 16'h0002;
    idle(6);
    expect_read("R6 rising ignored when falling selected", 6'h1C, 16'h0000);
    pin_in = 16'h0000;
    idle(6);
    expect_read("R6 falling edge latched", 6'h1C, 16'h0002);

    // R10: clear semantics
    bus_write(6'h24, 16'h0001);
    expect_read("R10 zero bit keeps latch", 6'h1C, 16'h0002);
    expect_read("R10 clear register reads 0", 6'h24, 16'h0000);
    bus_write(6'h24, 16'h0002);
    expect_read("R10 one bit clears latch", 6'h1C, 16'h0000);

    // R7: both edges
    bus_write(6'h10, 16'h0004);
    pin_in = 16'h0004;
    idle(6);
    expect_read("R7 rising with both edges", 6'h1C, 16'h0004);
    bus_write(6'h24, 16'h0004);
    pin_in = 16'h0000;
    idle(6);
    expect_read("R7 falling with both edges", 6'h1C, 16'h0004);
    bus_write(6'h24, 16'h0004);
    expect_read("R7 cleared", 6'h1C, 16'h0000);

    // R8: level sense
    bus_write(6'h0C, 16'h0008);
    bus_write(6'h14, 16'h0009);
    pin_in = 16'h0008;
    idle(6);
    expect_read("R8 high level", 6'h1C, 16'h0008);
    bus_write(6'h24, 16'h0008);
    expect_read("R8 clear has no effect on level", 6'h1C, 16'h0008);
    pin_in = 16'h0000;
    idle(6);
    expect_read("R8 level follows pin", 6'h1C, 16'h0000);
    bus_write(6'h14, 16'h0001);
    expect_read("R8 low level with polarity 0", 6'h1C, 16'h0008);

    // R9 / R11: enables
    bus_write(6'h18, 16'h0000);
    idle(3);
    expect_read("R9 masked status disabled", 6'h20, 16'h0000);
    expect_read("R9 raw status unaffected by enable", 6'h1C, 16'h0008);
    check("R11 irq off when disabled", {31'd0, irq}, 32'd0);
    bus_write(6'h18, 16'h0008);
    idle(3);
    expect_read("R9 masked status re-enabled", 6'h20, 16'h0008);
    check("R11 irq on when enabled", {31'd0, irq}, 32'd1);

    // R12: decode corner cases
    expect_read("R12 misaligned read", 6'h1D, 16'h0000);
    expect_read("R12 unmapped read", 6'h28, 16'h0000);
    bus_write(6'h09, 16'hFFFF);
    expect_read("R12 misaligned write ignored", 6'h08, 16'h0000);
    bus_write(6'h2C, 16'hFFFF);
    expect_read("R12 unmapped write leaves mask", 6'h04, 16'hFFFF);

    // random traffic, checked against the model every clock
    for (int k = 0; k < 1500; k++) begin
      int c;
      c = int'($urandom_range(0, 9));
      if (c < 4) begin
        pin_in = pin_in ^ W'($urandom) & W'($urandom);
        idle(1);
      end else if (c < 7) begin
        bus_write(AW'($urandom_range(0, 15) * 4), W'($urandom));
      end else begin
        bus_read(AW'($urandom_range(0, 63)), d);
      end
    end

    // R1: reset again from a busy state
    pin_in = '0;
    idle(4);
    @(negedge clk); rst = 1;
    idle(3);
    rst = 0;
    idle(2);
    check("R1 irq after second reset", {31'd0, irq}, 32'd0);
    for (int r = 0; r < 10; r++) expect_read("R1 register value after second reset", AW'(r * 4), '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule